// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out the byte moves for the channel an arbiter has granted. When the grant arrives it loads that channel's current address and remaining count. Then, for each byte, it presents the address and pulses the read and write strobes for the transfer direction. After every byte it returns the stepped address and the decremented count on a write-back port, so the surrounding register file can store them.

The 16-bit address is split across two sets of lines. The low byte goes out on dedicated lines. The high byte goes out on the shared data lines, together with an address strobe, but only for the first byte of a grant or when the high byte has changed since the last strobe.

Three transfer modes are supported: one byte per grant, a full block, and a demand mode that pauses when the peripheral's request drops. There is also a memory-to-memory mode. In that mode channel 0 supplies the source address and channel 1 the destination, and each byte passes through an internal holding byte. The source address can be frozen so that a single byte fills a whole region. A programmed count of N moves N+1 bytes.

Top module: `dmaXferSeq`

## Requirements
- R1: After reset the block is idle. All bus strobes, the address strobe, the write-back valid, the terminal flags, the end-of-process output and the done output are low.
- R2: In block mode (`xferMode` = 2'b01) a loaded count of N moves N+1 bytes. Each byte's write-back carries the channel, the stepped address and the count minus one, in the same cycle as that byte's strobes, while `addrLo` shows the unstepped low address byte.
- R3: With `addrDown` = 1 the address decreases by one per byte; with `addrDown` = 0 it increases by one, wrapping modulo 2^16.
- R4: `adrStrobe` pulses, with `dataOut` carrying the high address byte and `dataOe` high, before the first byte of each grant and whenever the high byte differs from the one last strobed. It does not pulse otherwise.
- R5: In single mode (`xferMode` = 2'b00) exactly one byte moves per grant. After that byte `xferDone` rises.
- R6: A high `eopIn` during a byte's strobe cycle ends the transfer after that byte, without setting a terminal flag.
- R7: In demand mode (`xferMode` = 2'b10) a low `reqLevel` during a byte's strobe cycle ends the grant after that byte. A later grant resumes from the written-back address and count.
- R8: A byte moved while the count is 0 rolls the count to FFFFh, pulses the channel's `tcFlag` bit and `eopOut` for one cycle, and ends the transfer.
- R9: In I/O mode, `memToIo` = 1 asserts `memRd` with `ioWr`, and `memToIo` = 0 asserts `ioRd` with `memWr`, for one cycle per byte.
- R10: With `memToMem` = 1, each byte is first read with `memRd` from channel 0's address, written back as channel 0, and latched from `dataIn`. It is then written with `memWr` to channel 1's address, with the latched byte on `dataOut`. Channel 1's count decides the terminal count.
- R11: With `memToMem` = 1 and `holdSource` = 1, channel 0's written-back address equals its loaded address on every byte, while its count still decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| grantValid | input | 1 | Grant held by the arbiter; drop after `xferDone` |
| grantCh | input | CH_W | Granted channel (I/O mode) |
| xferMode | input | 2 | 00 single, 01 block, 10 demand, 11 as block |
| addrDown | input | 1 | 1 decrements the address per byte |
| memToMem | input | 1 | Memory-to-memory through channels 0 and 1 |
| holdSource | input | 1 | Freeze channel 0 address in memory-to-memory |
| memToIo | input | 1 | I/O direction: 1 memory to device, 0 device to memory |
| curAddrIn | input | NUM_CH x 2*DATA_W | Current address of every channel |
| curCntIn | input | NUM_CH x CNT_W | Current count of every channel |
| eopIn | input | 1 | External end-of-process |
| reqLevel | input | 1 | Live request level (demand mode) |
| dataIn | input | DATA_W | Read data for memory-to-memory |
| addrLo | output | DATA_W | Low address byte |
| dataOut | output | DATA_W | High address byte or held data byte |
| dataOe | output | 1 | Data lines driven |
| adrStrobe | output | 1 | High address byte valid on `dataOut` |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| updValid | output | 1 | Write-back valid |
| updCh | output | CH_W | Write-back channel |
| updAddr | output | 2*DATA_W | Stepped address |
| updCnt | output | CNT_W | Decremented count |
| tcFlag | output | NUM_CH | Terminal-count pulse per channel |
| eopOut | output | 1 | End-of-process pulse on terminal count |
| xferDone | output | 1 | Grant finished; held until the grant drops |

## Verification
The bench builds the block with its defaults: 8-bit data, four channels and 16-bit counts. Small loaded counts reach the terminal count, including the roll from 0 to FFFFh, in a few bytes. Start addresses next to a 256-byte boundary, in both directions, make the high-byte strobe fire mid-transfer, and the source and destination in memory-to-memory mode sit in different pages. Four channels let the bench drive every grant index and keep channels 0 and 1 free for the paired mode.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_BLOCK  = 2'b01;
  localparam logic [1:0] MODE_DEMAND = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ADR, ST_XFER, ST_MRD, ST_MWR, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic load;
    logic addrPhase;
    logic dstSel;
    logic stepSrc;
    logic stepDst;
    logic capTemp;
    logic drvTemp;
  } seqCtl_t;

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  seqCtl_t                             ctl,
  input  logic [$clog2(NUM_CH)-1:0]           grantCh,
  input  logic [NUM_CH-1:0][2*DATA_W-1:0]     curAddrIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]        curCntIn,
  input  logic                                addrDown,
  input  logic                                holdSource,
  input  logic                                memToMem,
  input  logic [DATA_W-1:0]                   dataIn,
  output logic [DATA_W-1:0]                   addrLo,
  output logic [DATA_W-1:0]                   dataOut,
  output logic                                dataOe,
  output logic                                adrStrobe,
  output logic                                updValid,
  output logic [$clog2(NUM_CH)-1:0]           updCh,
  output logic [2*DATA_W-1:0]                 updAddr,
  output logic [CNT_W-1:0]                    updCnt,
  output logic                                srcZero,
  output logic                                dstZero
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int CH_W   = $clog2(NUM_CH);

  logic [ADDR_W-1:0] srcAddr, dstAddr, busAddr, stepVal, nextSrcAddr, nextDstAddr;
  logic [CNT_W-1:0]  srcCnt, dstCnt;
  logic [CH_W-1:0]   srcCh, srcChSel;
  logic [DATA_W-1:0] lastHi, tempByte, busHi;
  logic              hiValid, hiChange;

  assign srcChSel    = memToMem ? '0 : grantCh;
  assign busAddr     = ctl.dstSel ? dstAddr : srcAddr;
  assign busHi       = busAddr[ADDR_W-1:DATA_W];
  assign hiChange    = !hiValid || (busHi != lastHi);
  assign adrStrobe   = ctl.addrPhase && hiChange;
  assign addrLo      = busAddr[DATA_W-1:0];
  assign dataOut     = adrStrobe ? busHi : tempByte;
  assign dataOe      = adrStrobe || ctl.drvTemp;

  assign stepVal     = addrDown ? {ADDR_W{1'b1}} : ADDR_W'(1);
  assign nextSrcAddr = (memToMem && holdSource) ? srcAddr : srcAddr + stepVal;
  assign nextDstAddr = dstAddr + stepVal;

  assign updValid    = ctl.stepSrc || ctl.stepDst;
  assign updCh       = ctl.stepDst ? CH_W'(1) : srcCh;
  assign updAddr     = ctl.stepDst ? nextDstAddr : nextSrcAddr;
  assign updCnt      = ctl.stepDst ? dstCnt - CNT_W'(1) : srcCnt - CNT_W'(1);
  assign srcZero     = (srcCnt == '0);
  assign dstZero     = (dstCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      srcCnt   <= '0;
      dstCnt   <= '0;
      srcCh    <= '0;
      lastHi   <= '0;
      hiValid  <= 1'b0;
      tempByte <= '0;
    end else begin
      if (ctl.load) begin
        srcCh   <= srcChSel;
        srcAddr <= curAddrIn[srcChSel];
        srcCnt  <= curCntIn[srcChSel];
        dstAddr <= curAddrIn[1];
        dstCnt  <= curCntIn[1];
        hiValid <= 1'b0;
      end else if (adrStrobe) begin
        lastHi  <= busHi;
        hiValid <= 1'b1;
      end
      if (ctl.stepSrc) begin
        srcAddr <= nextSrcAddr;
        srcCnt  <= srcCnt - CNT_W'(1);
      end
      if (ctl.stepDst) begin
        dstAddr <= nextDstAddr;
        dstCnt  <= dstCnt - CNT_W'(1);
      end
      if (ctl.capTemp) tempByte <= dataIn;
    end
  end

  // R2: each source step lowers the count by exactly one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepSrc |=> srcCnt == $past(srcCnt) - CNT_W'(1));

  // R11: a frozen source keeps its address across a step
  a_r11_hold_source: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepSrc && memToMem && holdSource) |=> srcAddr == $past(srcAddr));

  // R4: the high-byte strobe never fires on two cycles in a row
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    adrStrobe |=> !adrStrobe);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       grantValid,
  input  logic [1:0] xferMode,
  input  logic       memToMem,
  input  logic       memToIo,
  input  logic       eopIn,
  input  logic       reqLevel,
  input  logic       srcZero,
  input  logic       dstZero,
  output seqCtl_t    ctl,
  output logic       memRd,
  output logic       memWr,
  output logic       ioRd,
  output logic       ioWr,
  output logic       tcHit,
  output logic       xferDone
);

  seqState_t state, nextState;
  logic      dstPhase, nextDstPhase, finish;

  assign finish = tcHit || eopIn || (xferMode == MODE_SINGLE) ||
                  ((xferMode == MODE_DEMAND) && !reqLevel);
  assign xferDone = (state == ST_DONE);

  always_comb begin
    ctl          = '0;
    memRd        = 1'b0;
    memWr        = 1'b0;
    ioRd         = 1'b0;
    ioWr         = 1'b0;
    tcHit        = 1'b0;
    nextState    = state;
    nextDstPhase = dstPhase;
    unique case (state)
      ST_IDLE: if (grantValid) nextState = ST_LOAD;
      ST_LOAD: begin
        ctl.load     = 1'b1;
        nextDstPhase = 1'b0;
        nextState    = ST_ADR;
      end
      ST_ADR: begin
        ctl.addrPhase = 1'b1;
        ctl.dstSel    = dstPhase;
        if (!memToMem)     nextState = ST_XFER;
        else if (dstPhase) nextState = ST_MWR;
        else               nextState = ST_MRD;
      end
      ST_XFER: begin
        ctl.stepSrc = 1'b1;
        memRd       = memToIo;
        ioWr        = memToIo;
        ioRd        = !memToIo;
        memWr       = !memToIo;
        tcHit       = srcZero;
        nextState   = finish ? ST_DONE : ST_ADR;
      end
      ST_MRD: begin
        memRd        = 1'b1;
        ctl.capTemp  = 1'b1;
        ctl.stepSrc  = 1'b1;
        nextDstPhase = 1'b1;
        nextState    = ST_ADR;
      end
      ST_MWR: begin
        ctl.dstSel   = 1'b1;
        ctl.drvTemp  = 1'b1;
        ctl.stepDst  = 1'b1;
        memWr        = 1'b1;
        tcHit        = dstZero;
        nextDstPhase = 1'b0;
        nextState    = finish ? ST_DONE : ST_ADR;
      end
      ST_DONE: if (!grantValid) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dstPhase <= 1'b0;
    end else begin
      state    <= nextState;
      dstPhase <= nextDstPhase;
    end
  end

  // R8: end-of-process is a single-cycle pulse
  a_r8_eop_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tcHit |=> !tcHit);

  // R5: a single-mode byte always closes the grant
  a_r5_single_done: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_XFER || state == ST_MWR) && xferMode == MODE_SINGLE) |=> state == ST_DONE);

  // R10: every write is preceded two cycles earlier by the read
  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MWR) |-> $past(state, 2) == ST_MRD);

endmodule

// File: rtl/dmaXferSeq.sv
module dmaXferSeq
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                grantValid,
  input  logic [$clog2(NUM_CH)-1:0]           grantCh,
  input  logic [1:0]                          xferMode,
  input  logic                                addrDown,
  input  logic                                memToMem,
  input  logic                                holdSource,
  input  logic                                memToIo,
  input  logic [NUM_CH-1:0][2*DATA_W-1:0]     curAddrIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]        curCntIn,
  input  logic                                eopIn,
  input  logic                                reqLevel,
  input  logic [DATA_W-1:0]                   dataIn,
  output logic [DATA_W-1:0]                   addrLo,
  output logic [DATA_W-1:0]                   dataOut,
  output logic                                dataOe,
  output logic                                adrStrobe,
  output logic                                memRd,
  output logic                                memWr,
  output logic                                ioRd,
  output logic                                ioWr,
  output logic                                updValid,
  output logic [$clog2(NUM_CH)-1:0]           updCh,
  output logic [2*DATA_W-1:0]                 updAddr,
  output logic [CNT_W-1:0]                    updCnt,
  output logic [NUM_CH-1:0]                   tcFlag,
  output logic                                eopOut,
  output logic                                xferDone
);

  seqCtl_t ctl;
  logic    srcZero, dstZero, tcHit;

  dma_seq_ctrl ctrl_i (
    .clk, .rstN, .grantValid, .xferMode, .memToMem, .memToIo, .eopIn, .reqLevel,
    .srcZero, .dstZero, .ctl, .memRd, .memWr, .ioRd, .ioWr, .tcHit, .xferDone
  );

  dma_seq_dp #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CNT_W(CNT_W)) dp_i (
    .clk, .rstN, .ctl, .grantCh, .curAddrIn, .curCntIn, .addrDown, .holdSource,
    .memToMem, .dataIn, .addrLo, .dataOut, .dataOe, .adrStrobe, .updValid,
    .updCh, .updAddr, .updCnt, .srcZero, .dstZero
  );

  assign eopOut = tcHit;
  assign tcFlag = tcHit ? (NUM_CH'(1) << updCh) : '0;

  // R8: at most one channel reaches terminal count at a time
  a_r8_tc_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tcFlag));

endmodule

// File: tb/dmaXferSeq_tb_top.sv
module dmaXferSeq_tb_top;

  localparam int NCH = 4;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic grantValid = 0, addrDown = 0, memToMem = 0, holdSource = 0, memToIo = 0;
  logic eopIn = 0, reqLevel = 1;
  logic [1:0] grantCh = 0, xferMode = 0;
  logic [NCH-1:0][15:0] curAddrIn = '0, curCntIn = '0;
  logic [7:0] dataIn, addrLo, dataOut;
  logic dataOe, adrStrobe, memRd, memWr, ioRd, ioWr, updValid, eopOut, xferDone;
  logic [1:0] updCh;
  logic [15:0] updAddr, updCnt;
  logic [NCH-1:0] tcFlag;

  assign dataIn = addrLo ^ 8'hA5;

  dmaXferSeq dut_i (.*);

  typedef struct {
    int ch; int code; logic [7:0] lo; logic [15:0] na; logic [15:0] nc;
    bit chk; logic [7:0] d; string tag;
  } item_t;

  item_t itemQ[$];
  logic [7:0] hiQ[$];
  int checks = 0, fails = 0;
  logic [15:0] modelA[NCH], modelC[NCH];
  logic [NCH-1:0] tcSeen;
  int eopSeen = 0, byteIdx = 0, eopByte = -1, dropByte = -1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int strobeCode();
    if (memRd && ioWr) return 1;
    if (ioRd && memWr) return 2;
    if (memRd) return 3;
    if (memWr) return 4;
    if (ioRd || ioWr) return 5;
    return 0;
  endfunction

  // monitor: pops expected items as the design produces them
  always @(negedge clk) if (rstN) begin
    int code;
    code = strobeCode();
    if (adrStrobe) begin
      if (hiQ.size() == 0) check(0, "R4 unexpected strobe", dataOut, 0);
      else begin
        logic [7:0] h;
        h = hiQ.pop_front();
        check(dataOut == h && dataOe, "R4 high byte", dataOut, h);
      end
    end
    if (updValid) begin
      if (itemQ.size() == 0) check(0, "R2 unexpected write-back", updAddr, 0);
      else begin
        item_t e;
        e = itemQ.pop_front();
        check(updCh == 2'(e.ch), {e.tag, " channel"}, updCh, e.ch);
        check(code == e.code, {e.tag, " R9 strobes"}, code, e.code);
        check(addrLo == e.lo, {e.tag, " addrLo"}, addrLo, e.lo);
        check(updAddr == e.na, {e.tag, " address"}, updAddr, e.na);
        check(updCnt == e.nc, {e.tag, " count"}, updCnt, e.nc);
        if (e.chk) check(dataOut == e.d && dataOe, {e.tag, " R10 data"}, dataOut, e.d);
      end
    end else if (code != 0) check(0, "R9 strobe without write-back", code, 0);
    tcSeen |= tcFlag;
    if (eopOut) eopSeen++;
    if (code == 1 || code == 2 || code == 4) begin
      eopIn = (byteIdx == eopByte);
      if (byteIdx == dropByte) reqLevel = 0;
      byteIdx++;
    end else eopIn = 0;
  end

  task automatic pushHi(inout bit hv, inout logic [7:0] lh, input logic [15:0] a);
    if (!hv || a[15:8] != lh) hiQ.push_back(a[15:8]);
    hv = 1; lh = a[15:8];
  endtask

  task automatic runXfer(input string tag, input int ch, input logic [1:0] mode, input bit dec,
                         input bit m2m, input bit hold, input bit dir, input int eb, input int db);
    bit hv = 0, fin = 0, tc;
    logic [7:0] lh = 0;
    logic [15:0] step;
    logic [NCH-1:0] expTc = '0;
    int expEop = 0, n = 0;
    step = dec ? 16'hFFFF : 16'h0001;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin curAddrIn[c] = modelA[c]; curCntIn[c] = modelC[c]; end
    grantCh = 2'(ch); xferMode = mode; addrDown = dec; memToMem = m2m;
    holdSource = hold; memToIo = dir; eopByte = eb; dropByte = db; byteIdx = 0;
    reqLevel = 1; tcSeen = '0; eopSeen = 0;
    for (int i = 0; !fin && i < 64; i++) begin
      item_t e;
      if (!m2m) begin
        pushHi(hv, lh, modelA[ch]);
        tc = (modelC[ch] == 0);
        e = '{ch, dir ? 1 : 2, modelA[ch][7:0], modelA[ch] + step, modelC[ch] - 1, 0, 0, tag};
        itemQ.push_back(e);
        modelA[ch] += step; modelC[ch] -= 1;
        if (tc) expTc = NCH'(1) << ch;
      end else begin
        logic [7:0] d;
        pushHi(hv, lh, modelA[0]);
        d = modelA[0][7:0] ^ 8'hA5;
        e = '{0, 3, modelA[0][7:0], hold ? modelA[0] : modelA[0] + step, modelC[0] - 1, 0, 0, tag};
        itemQ.push_back(e);
        if (!hold) modelA[0] += step;
        modelC[0] -= 1;
        pushHi(hv, lh, modelA[1]);
        tc = (modelC[1] == 0);
        e = '{1, 4, modelA[1][7:0], modelA[1] + step, modelC[1] - 1, 1, d, tag};
        itemQ.push_back(e);
        modelA[1] += step; modelC[1] -= 1;
        if (tc) expTc = 4'b0010;
      end
      if (tc) expEop = 1;
      fin = tc || (i == eb) || (mode == 2'b00) || (mode == 2'b10 && i == db);
    end
    grantValid = 1;
    while (!xferDone && n < 2000) begin @(negedge clk); n++; end
    check(xferDone, {tag, " done reached"}, xferDone, 1);
    if (!xferDone) finishRun();
    repeat (2) @(negedge clk);
    check(tcSeen == expTc, {tag, " R8 tc flags"}, tcSeen, expTc);
    check(eopSeen == expEop, {tag, " R8 eop pulses"}, eopSeen, expEop);
    check(itemQ.size() == 0 && hiQ.size() == 0, {tag, " all bytes moved"}, itemQ.size(), 0);
    itemQ.delete(); hiQ.delete();
    grantValid = 0; eopByte = -1; dropByte = -1;
    @(negedge clk);
    reqLevel = 1;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin modelA[c] = 0; modelC[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!(memRd | memWr | ioRd | ioWr | adrStrobe | updValid | eopOut | xferDone) && tcFlag == 0,
          "R1 reset idle", {memRd, memWr, ioRd, ioWr, adrStrobe, updValid, eopOut, xferDone}, 0);
    // R2 R4 R9: block, incrementing across a page, memory to device
    modelA[2] = 16'h00FE; modelC[2] = 3;
    runXfer("R2 block", 2, 2'b01, 0, 0, 0, 1, -1, -1);
    // R3: decrementing across a page, device to memory
    modelA[3] = 16'h0201; modelC[3] = 2;
    runXfer("R3 down", 3, 2'b01, 1, 0, 0, 0, -1, -1);
    // R5: single mode, one byte
    modelA[1] = 16'h4410; modelC[1] = 5;
    runXfer("R5 single", 1, 2'b00, 0, 0, 0, 1, -1, -1);
    // R6: external end-of-process at the third byte
    modelA[0] = 16'h1234; modelC[0] = 10;
    runXfer("R6 eop", 0, 2'b01, 0, 0, 0, 0, 2, -1);
    // R7: demand pauses after the second byte, then resumes to terminal count
    modelA[2] = 16'h30FF; modelC[2] = 6;
    runXfer("R7 demand pause", 2, 2'b10, 0, 0, 0, 1, -1, 1);
    runXfer("R7 demand resume", 2, 2'b10, 0, 0, 0, 1, -1, -1);
    // R10: memory to memory, three bytes
    modelA[0] = 16'h10FF; modelC[0] = 7; modelA[1] = 16'h2000; modelC[1] = 2;
    runXfer("R10 mem2mem", 0, 2'b01, 0, 1, 0, 0, -1, -1);
    // R11: fill with a frozen source
    modelA[0] = 16'h5555; modelC[0] = 9; modelA[1] = 16'h6000; modelC[1] = 3;
    runXfer("R11 fill", 0, 2'b01, 0, 1, 1, 0, -1, -1);
    // R8: count of zero rolls to FFFF on a single byte
    modelA[3] = 16'hFFFF; modelC[3] = 0;
    runXfer("R8 roll", 3, 2'b00, 0, 0, 0, 1, -1, -1);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

endmodule